// File: doc/BRIEF.md
# Sector Protection and Lock Unit

This unit holds the write-protection state of a 512 KB serial flash array that is cut into eleven physical sectors of unequal size. Each sector has one protection flag. The unit answers whether the sector that holds a given address is protected. It gives the answer as a single bit and as the byte that a protection-register read returns. It also produces the two status fields that the status register shows: the lock flag and a two-bit summary of the protection state.

The command decoder in front of the unit presents each command as a one-cycle strobe. A strobe comes with a 24-bit command address or with a status-write data byte. There are three strobes: mark one sector protected, mark one sector unprotected, and status write. A status write carries the lock flag in bit 7 and the global protection field in bits 3:2. An active-low write-protect pin works together with the lock flag. When the pin is low and the lock flag is set, the lock is held in hardware and cannot be cleared.

Top module: `sect_guard`

## Requirements
- R1: After reset, all eleven protection flags are 1, the lock flag is 0 and the summary reads 2'b11.
- R2: The sector map over array offsets is fixed. Sectors 0 to 6 are the 64 KB regions from 0x00000 to 0x6FFFF. Sector 7 is the 32 KB region 0x70000–0x77FFF. Sectors 8 and 9 are the 8 KB regions 0x78000–0x79FFF and 0x7A000–0x7BFFF. Sector 10 is the 16 KB region 0x7C000–0x7FFFF.
- R3: Address bits 23:19 are ignored, so an address at or above 512 KB refers to the same sector as its low 19 bits.
- R4: While the lock flag is 0, a protect strobe sets the flag of the addressed sector only, and an unprotect strobe clears the flag of the addressed sector only. The change is visible after the clock edge that samples the strobe.
- R5: While the lock flag is 1, protect and unprotect strobes leave every flag unchanged. For the cycle after the strobe, `wel_drop` is 1. At all other times `wel_drop` is 0.
- R6: `status_swp` is 2'b00 when no sector is protected, 2'b11 when all sectors are protected and 2'b01 otherwise. It never shows 2'b10.
- R7: `query_prot` is the flag of the sector that holds `query_addr`. `query_byte` is 8'hFF when that sector is protected and 8'h00 when it is not.
- R8: A status write with data bit 7 = 1 sets the lock flag, whatever the level of the pin.
- R9: A status write with data bit 7 = 0 clears the lock flag only while `wp_n` is 1. While `wp_n` is 0 the lock flag stays set.
- R10: When the lock flag is 0 and data bit 7 = 0, a status write with data bits 3:2 = 2'b11 sets all flags and one with 2'b00 clears all flags. With 2'b01 or 2'b10 the flags do not change.
- R11: A status write changes no flag when the lock flag is 1 or when data bit 7 = 1. In both cases the lock is either set or changing.
- R12: When strobes arrive together, status write goes first, then protect, then unprotect. Only the first strobe in that order takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_protect | input | 1 | Protect-sector strobe |
| cmd_unprotect | input | 1 | Unprotect-sector strobe |
| cmd_status_wr | input | 1 | Status-write strobe |
| cmd_addr | input | 24 | Address for protect/unprotect |
| status_data | input | 8 | Status-write byte (bit 7 lock, bits 3:2 global) |
| query_addr | input | 24 | Address to look up |
| query_prot | output | 1 | Protection flag of the looked-up sector |
| query_byte | output | 8 | Protection-register read value (FFh/00h) |
| status_lock | output | 1 | Lock flag |
| status_swp | output | 2 | Protection summary |
| wel_drop | output | 1 | Pulse: a sector command was refused by the lock |

## Verification
The assertions check the following on every cycle: an address hits exactly one sector, a locked unit ignores sector commands and raises `wel_drop`, a status write under lock leaves the flags alone, the lock stays set while the pin is low, the summary code is never reserved, and the query byte has only two values. The actual sector boundaries, the aliasing of high addresses, the global set and clear codes, the strobe priority and the reset contents can only be shown by the bench. It drives directed boundary addresses and random command streams, and compares the results against its own model of the sector map.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;
  localparam int NSECT   = 11;
  localparam int IDX_W   = $clog2(NSECT);

  typedef logic [NSECT-1:0] sect_vec_t;

  // Array offset (19 bits) to sector number; large sectors sit low,
  // the small ones sit in the top 64 KB.
  function automatic logic [IDX_W-1:0] sector_index(input logic [18:0] off);
    if (off[18:16] != 3'd7)  return IDX_W'(off[18:16]);
    else if (!off[15])       return IDX_W'(7);
    else if (off[14])        return IDX_W'(10);
    else if (!off[13])       return IDX_W'(8);
    else                     return IDX_W'(9);
  endfunction

  function automatic logic [1:0] summary_code(input sect_vec_t v);
    if (&v)      return 2'b11;
    else if (|v) return 2'b01;
    else         return 2'b00;
  endfunction
endpackage

// File: rtl/sect_map.sv
module sect_map
  import sect_guard_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ARRAY_AW = 19
) (
  input  logic [ADDR_W-1:0] addr,
  output sect_vec_t         hit
);
  logic [ARRAY_AW-1:0] off;
  logic [IDX_W-1:0]    idx;

  assign off = addr[ARRAY_AW-1:0];
  assign idx = sector_index(off);

  for (genvar i = 0; i < NSECT; i++) begin : g_hit
    assign hit[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/prot_bank.sv
module prot_bank
  import sect_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sect_vec_t set_vec,
  input  sect_vec_t clr_vec,
  input  logic      set_all,
  input  logic      clr_all,
  output sect_vec_t prot_vec
);
  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        prot_vec[i] <= 1'b1;
      else if (set_all || set_vec[i])    prot_vec[i] <= 1'b1;
      else if (clr_all || clr_vec[i])    prot_vec[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_lock,
  input  logic wp_n,
  output logic lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lock <= 1'b0;
    else if (wr && wr_lock)   lock <= 1'b1;
    else if (wr && wp_n)      lock <= 1'b0;
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sect_guard_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 19,
  parameter int DATA_W   = 8,
  parameter int LOCK_BIT = 7,
  parameter int GLB_LO   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_protect,
  input  logic              cmd_unprotect,
  input  logic              cmd_status_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] status_data,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_prot,
  output logic [DATA_W-1:0] query_byte,
  output logic              status_lock,
  output logic [1:0]        status_swp,
  output logic              wel_drop
);
  sect_vec_t cmd_hit, q_hit, prot_vec, set_vec, clr_vec;
  logic do_prot, do_unprot, sect_req, blocked, glb_ok, set_all, clr_all;
  logic [1:0] glb_field;

  sect_map #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_cmap (.addr(cmd_addr),   .hit(cmd_hit));
  sect_map #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_qmap (.addr(query_addr), .hit(q_hit));

  // strobe priority: status write, then protect, then unprotect
  assign do_prot   = cmd_protect & ~cmd_status_wr;
  assign do_unprot = cmd_unprotect & ~cmd_status_wr & ~cmd_protect;
  assign sect_req  = do_prot | do_unprot;
  assign blocked   = sect_req & status_lock;

  assign glb_field = status_data[GLB_LO+1:GLB_LO];
  assign glb_ok    = cmd_status_wr & ~status_lock & ~status_data[LOCK_BIT];
  assign set_all   = glb_ok & (glb_field == 2'b11);
  assign clr_all   = glb_ok & (glb_field == 2'b00);

  assign set_vec = (do_prot   & ~status_lock) ? cmd_hit : '0;
  assign clr_vec = (do_unprot & ~status_lock) ? cmd_hit : '0;

  prot_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .set_all(set_all), .clr_all(clr_all), .prot_vec(prot_vec)
  );

  lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .wr(cmd_status_wr),
    .wr_lock(status_data[LOCK_BIT]), .wp_n(wp_n), .lock(status_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_drop <= 1'b0;
    else        wel_drop <= blocked;
  end

  assign query_prot = |(prot_vec & q_hit);
  assign query_byte = {DATA_W{query_prot}};
  assign status_swp = summary_code(prot_vec);
endmodule

// File: rtl/sect_guard_chk.sv
module sect_guard_chk
  import sect_guard_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       cmd_protect,
  input logic       cmd_unprotect,
  input logic       cmd_status_wr,
  input logic       status_lock,
  input logic [1:0] status_swp,
  input logic [7:0] query_byte,
  input logic       wel_drop,
  input sect_vec_t  cmd_hit,
  input sect_vec_t  prot_vec
);
  assert_one_sector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_hit) == 1);

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lock && (cmd_protect || cmd_unprotect) && !cmd_status_wr)
      |=> (prot_vec == $past(prot_vec)));

  assert_locked_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lock && (cmd_protect || cmd_unprotect) && !cmd_status_wr) |=> wel_drop);

  assert_wel_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_protect || cmd_unprotect) |=> !wel_drop);

  assert_swp_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_swp != 2'b10);

  assert_query_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (query_byte == 8'hFF) || (query_byte == 8'h00));

  assert_lock_hw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lock && !wp_n) |=> status_lock);

  assert_glb_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_status_wr && status_lock) |=> (prot_vec == $past(prot_vec)));
endmodule

bind sect_guard sect_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
  .cmd_protect(cmd_protect), .cmd_unprotect(cmd_unprotect),
  .cmd_status_wr(cmd_status_wr), .status_lock(status_lock),
  .status_swp(status_swp), .query_byte(query_byte), .wel_drop(wel_drop),
  .cmd_hit(cmd_hit), .prot_vec(prot_vec)
);

// File: tb/sim_sect_guard.sv
`timescale 1ns/1ps
module sim_sect_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_protect = 1'b0, cmd_unprotect = 1'b0, cmd_status_wr = 1'b0;
  logic [23:0] cmd_addr = '0, query_addr = '0;
  logic [7:0] status_data = '0;
  logic query_prot, status_lock, wel_drop;
  logic [7:0] query_byte;
  logic [1:0] status_swp;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [10:0] m_prot;
  logic m_lock, m_wel;

  always #2.5 clk = ~clk;

  sect_guard u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_protect(cmd_protect),
    .cmd_unprotect(cmd_unprotect), .cmd_status_wr(cmd_status_wr),
    .cmd_addr(cmd_addr), .status_data(status_data), .query_addr(query_addr),
    .query_prot(query_prot), .query_byte(query_byte), .status_lock(status_lock),
    .status_swp(status_swp), .wel_drop(wel_drop)
  );

  // range-based restatement of the sector map
  function automatic int sect_of(input logic [23:0] a);
    int o = int'(a & 24'h07FFFF);
    if (o < 'h70000) return o / 'h10000;
    if (o < 'h78000) return 7;
    if (o < 'h7A000) return 8;
    if (o < 'h7C000) return 9;
    return 10;
  endfunction

  function automatic logic [1:0] exp_swp(input logic [10:0] v);
    int n = 0;
    for (int i = 0; i < 11; i++) n += v[i];
    return (n == 0) ? 2'b00 : (n == 11) ? 2'b11 : 2'b01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [23:0] a);
    query_addr = a;
    #0.5;
    check(req, query_prot, m_prot[sect_of(a)]);
    check(req, query_byte, m_prot[sect_of(a)] ? 8'hFF : 8'h00);
  endtask

  task automatic check_status(input string req);
    check(req, status_lock, m_lock);
    check(req, status_swp, exp_swp(m_prot));
    check(req, wel_drop, m_wel);
  endtask

  // one command cycle; model updated from the requirements
  task automatic op(input logic p, input logic u, input logic s,
                    input logic [23:0] a, input logic [7:0] d);
    logic old_lock;
    int k;
    @(negedge clk);
    cmd_protect = p; cmd_unprotect = u; cmd_status_wr = s;
    cmd_addr = a; status_data = d;
    @(posedge clk);
    old_lock = m_lock;
    k = sect_of(a);
    m_wel = 1'b0;
    if (s) begin
      if (d[7]) m_lock = 1'b1;
      else if (wp_n) m_lock = 1'b0;
      if (!old_lock && !d[7]) begin
        if (d[3:2] == 2'b11) m_prot = '1;
        else if (d[3:2] == 2'b00) m_prot = '0;
      end
    end else if (p || u) begin
      if (old_lock) m_wel = 1'b1;
      else m_prot[k] = p;
    end
    @(negedge clk);
    cmd_protect = 0; cmd_unprotect = 0; cmd_status_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] bnd [16];
    void'($urandom(1234));
    m_prot = '1; m_lock = 0; m_wel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents
    check_status("R1");
    look("R1", 24'h000000);

    // R2 boundaries: clear all, then protect one boundary at a time
    op(0, 0, 1, '0, 8'h00);
    check_status("R10");
    bnd = '{24'h000000, 24'h0FFFF, 24'h10000, 24'h6FFFF, 24'h70000, 24'h77FFF,
            24'h78000, 24'h79FFF, 24'h7A000, 24'h7BFFF, 24'h7C000, 24'h7FFFF,
            24'h3FFFF, 24'h40000, 24'h5A5A5, 24'h7DEAD};
    foreach (bnd[i]) begin
      op(1, 0, 0, bnd[i], 8'h00);
      look("R2", bnd[i]);
      look("R2", bnd[i] ^ 24'h001000);
      look("R2", bnd[i] + 24'h002000);
      check_status("R4");
      op(0, 1, 0, bnd[i], 8'h00);
      look("R4", bnd[i]);
    end
    // R3 aliasing
    op(1, 0, 0, 24'hF7A123, 8'h00);
    look("R3", 24'h07A000);
    look("R3", 24'h27BFFF);
    look("R7", 24'h000000);

    // R10 no-change codes and global set
    op(0, 0, 1, '0, 8'h04);
    check_status("R10");
    op(0, 0, 1, '0, 8'h08);
    check_status("R10");
    op(0, 0, 1, '0, 8'h0C);
    check_status("R10");

    // R8 lock with pin low, R5 refusal, R9 hardware hold, R11 skip
    wp_n = 1'b0;
    op(0, 0, 1, '0, 8'h80);
    check_status("R8");
    op(0, 1, 0, 24'h012345, 8'h00);
    check_status("R5");
    look("R5", 24'h012345);
    @(negedge clk); m_wel = 0;
    check_status("R5");
    op(0, 0, 1, '0, 8'h00);
    check_status("R9");
    op(0, 0, 1, '0, 8'h00);
    check_status("R11");
    wp_n = 1'b1;
    op(0, 0, 1, '0, 8'h00);
    check_status("R9");
    check_status("R11");
    op(0, 0, 1, '0, 8'h80);
    check_status("R11");
    op(0, 0, 1, '0, 8'h00);
    op(0, 0, 1, '0, 8'h00);
    check_status("R10");

    // R12 priority
    op(1, 1, 0, 24'h020000, 8'h00);
    look("R12", 24'h020000);
    op(1, 1, 1, 24'h030000, 8'h0C);
    check_status("R12");
    look("R12", 24'h030000);
    op(0, 1, 1, 24'h030000, 8'h04);
    look("R12", 24'h030000);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      logic [23:0] a = 24'($urandom);
      logic [7:0] d = 8'($urandom);
      wp_n = ($urandom_range(0, 3) != 0);
      if (r < 8) op(0, 0, 1, a, d);
      else if (r < 14) op(0, 0, 1, a, {1'b0, d[6:0]});
      else op(r[0], ~r[0] | r[1], 1'b0, a, d);
      check_status("R6");
      look("R7", 24'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule